// File: doc/BRIEF.md
# Low-Window Memory Bank Remapper

This block turns a 16-bit CPU address into a 19-bit address for a 512 KB external SRAM. Two programmable registers, a window base and a window mask, mark out a region of the CPU address space. An access that falls inside that region is flagged as banked. In that case the upper physical address bits that the mask does not keep come from a page register. Any access outside the region reaches the SRAM at the same address, with the three extra physical bits held at zero.

The main use is swapping a ROM image that sits in the low 8 KB of CPU space for RAM. After reset the window covers 0x0000–0x1FFF and maps to physical page 0. A single I/O write to port 0x38, whatever data the CPU puts on the bus, loads the page register with 0x20. From then on the low window lands on a different 64 KB region of the SRAM. Software can also write the three registers directly through a small register-write port. Translation is combinational from the current register contents. Register changes take effect from the clock edge that captures the write.

Top module: `bank_remapper`

## Requirements
- R1: After synchronous active-low reset the window base is 0x00, the window mask is 0x1C and the page register is 0x00. As a result, CPU addresses 0x0000–0x1FFF are banked and map to the same physical address, and 0x2000 and above are not banked.
- R2: Window match. Bit k of the base and mask registers lines up with CPU address bit k+8. Only CPU bits 15..11 take part in the compare. An access is banked when, for every such bit whose mask bit is 0, the CPU bit equals the base bit.
- R3: When banked, physical bits 10..0 equal CPU bits 10..0. Each physical bit i in 11..15 equals CPU bit i if mask bit i-8 is 1, and otherwise equals page-register bit i-11. Physical bits 18..16 equal page-register bits 7..5.
- R4: When not banked, physical address = {3'b000, CPU address}.
- R5: A cycle with io_wr high and io_port = 0x38 loads 0x20 into the page register. For example, with the reset window, CPU 0x0ABC then maps to 0x10ABC.
- R6: An I/O write to any port other than 0x38 has no effect on the translation.
- R7: A cycle with reg_we high writes reg_wdata into the register picked by reg_sel (0 = base, 1 = mask, 2 = page). reg_sel = 3 writes nothing. The new value governs translation from the next cycle on.
- R8: If a swap write to port 0x38 and a page-register write by reg_we arrive in the same cycle, the page register takes 0x20.
- R9: A reset after a swap returns the low window to physical page 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_a | input | 16 | CPU address being translated |
| io_wr | input | 1 | Regular I/O write strobe, one cycle per write |
| io_port | input | 8 | I/O port address of the write |
| reg_we | input | 1 | Register write enable |
| reg_sel | input | 2 | Register select: 0 base, 1 mask, 2 page |
| reg_wdata | input | 8 | Register write data |
| phys_a | output | 19 | SRAM address |
| banked | output | 1 | High while cpu_a is inside the window |

## Verification
The bench builds the block with its default parameters: a 16-bit CPU address, a 19-bit physical address, compare bits 15..11 and swap port 0x38. These values reach the real swap from a low 8 KB ROM window to page 0x20. Random base and mask values move and resize the window, from 2 KB up to the whole 64 KB, so every combination of kept and replaced bits in 11..15 is exercised. About half of the random addresses are steered to match the base, so banked and unbanked accesses both occur often.

// File: rtl/bank_remap_pkg.sv
// Package: shared widths, register selects and reset values for the
// bank remapper. Assumes CPU_AW - REG_W <= PASS_W < CPU_AW.
package bank_remap_pkg;
    localparam int CPU_AW = 16;   // CPU address width
    localparam int PHY_AW = 19;   // SRAM address width
    localparam int REG_W  = 8;    // register width
    localparam int PASS_W = 11;   // CPU bits always passed through

    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_PAGE = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/bank_regs.sv
// Module: holds window base, window mask and page register.
// Base and mask keep only the bits that take part in the compare.
// An I/O swap write has priority over a page write from the register port.
// Assumes one write per register per cycle; synchronous active-low reset.
module bank_regs #(
    parameter int          CPU_AW    = 16,
    parameter int          PHY_AW    = 19,
    parameter int          REG_W     = 8,
    parameter int          PASS_W    = 11,
    parameter logic [7:0]  SWAP_PORT = 8'h38,
    parameter logic [REG_W-1:0] SWAP_VAL  = 8'h20,
    parameter logic [REG_W-1:0] RST_BASE  = 8'h00,
    parameter logic [REG_W-1:0] RST_MASK  = 8'h1C,
    parameter logic [REG_W-1:0] RST_PAGE  = 8'h00
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       io_wr,
    input  logic [7:0]                 io_port,
    input  logic                       reg_we,
    input  logic [1:0]                 reg_sel,
    input  logic [REG_W-1:0]           reg_wdata,
    output logic [CPU_AW-PASS_W-1:0]   base_q,
    output logic [CPU_AW-PASS_W-1:0]   mask_q,
    output logic [PHY_AW-PASS_W-1:0]   page_q
);
    import bank_remap_pkg::*;

    localparam int CMP_W = CPU_AW - PASS_W;
    localparam int LO    = REG_W - CMP_W;   // lowest stored register bit

    logic swap_hit;

    // Decode a regular I/O write to the swap port.
    always_comb swap_hit = io_wr && (io_port == SWAP_PORT);

    // Window base and mask register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= RST_BASE[REG_W-1:LO];
            mask_q <= RST_MASK[REG_W-1:LO];
        end else if (reg_we) begin
            if (reg_sel == SEL_BASE) base_q <= reg_wdata[REG_W-1:LO];
            if (reg_sel == SEL_MASK) mask_q <= reg_wdata[REG_W-1:LO];
        end
    end

    // Page register update; the swap write wins over a port write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            page_q <= RST_PAGE;
        else if (swap_hit)
            page_q <= SWAP_VAL;
        else if (reg_we && reg_sel == SEL_PAGE)
            page_q <= reg_wdata;
    end
endmodule

// File: rtl/bank_window_match.sv
// Module: decides whether a CPU address lies in the window. Each compare
// bit matches when it is masked (kept from the CPU) or equals the base.
// Purely combinational.
module bank_window_match #(
    parameter int CPU_AW = 16,
    parameter int PASS_W = 11
) (
    input  logic [CPU_AW-1:0]        cpu_a,
    input  logic [CPU_AW-PASS_W-1:0] base_q,
    input  logic [CPU_AW-PASS_W-1:0] mask_q,
    output logic                     in_win
);
    localparam int CMP_W = CPU_AW - PASS_W;

    logic [CMP_W-1:0] bit_ok;

    for (genvar j = 0; j < CMP_W; j++) begin : g_cmp
        // One compare bit: masked, or equal to the base bit.
        always_comb bit_ok[j] = mask_q[j] | (cpu_a[PASS_W+j] == base_q[j]);
    end

    // All compare bits must agree for a window hit.
    always_comb in_win = &bit_ok;
endmodule

// File: rtl/bank_addr_compose.sv
// Module: builds the SRAM address. Low PASS_W bits always come from the CPU.
// Inside the window the remaining bits are taken from the CPU where masked
// and from the page register otherwise. Outside it the CPU address is
// zero-extended. Purely combinational.
module bank_addr_compose #(
    parameter int CPU_AW = 16,
    parameter int PHY_AW = 19,
    parameter int PASS_W = 11
) (
    input  logic [CPU_AW-1:0]        cpu_a,
    input  logic [CPU_AW-PASS_W-1:0] mask_q,
    input  logic [PHY_AW-PASS_W-1:0] page_q,
    input  logic                     in_win,
    output logic [PHY_AW-1:0]        phys_a
);
    for (genvar i = 0; i < PHY_AW; i++) begin : g_bit
        if (i < PASS_W) begin : g_pass
            // Offset bits pass straight through.
            always_comb phys_a[i] = cpu_a[i];
        end else if (i < CPU_AW) begin : g_mix
            // Compare bits: CPU bit when masked, page bit otherwise.
            always_comb phys_a[i] = (in_win && !mask_q[i-PASS_W]) ? page_q[i-PASS_W]
                                                                 : cpu_a[i];
        end else begin : g_high
            // Extra physical bits: page bit in window, zero outside.
            always_comb phys_a[i] = in_win & page_q[i-PASS_W];
        end
    end
endmodule

// File: rtl/bank_remapper.sv
// Module: top of the low-window bank remapper. Registers a window base,
// mask and page value and translates the CPU address to an SRAM address.
// Assumes a single clock and synchronous active-low reset; bus timing is
// handled outside.
module bank_remapper
    import bank_remap_pkg::*;
#(
    parameter logic [7:0] SWAP_PORT = 8'h38,
    parameter logic [7:0] SWAP_VAL  = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_a,
    input  logic              io_wr,
    input  logic [7:0]        io_port,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [PHY_AW-1:0] phys_a,
    output logic              banked
);
    localparam int CMP_W  = CPU_AW - PASS_W;
    localparam int PAGE_W = PHY_AW - PASS_W;

    logic [CMP_W-1:0]  base_q;
    logic [CMP_W-1:0]  mask_q;
    logic [PAGE_W-1:0] page_q;

    bank_regs #(
        .CPU_AW(CPU_AW), .PHY_AW(PHY_AW), .REG_W(REG_W), .PASS_W(PASS_W),
        .SWAP_PORT(SWAP_PORT), .SWAP_VAL(SWAP_VAL),
        .RST_BASE(8'h00), .RST_MASK(8'h1C), .RST_PAGE(8'h00)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_port(io_port),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .base_q(base_q), .mask_q(mask_q), .page_q(page_q)
    );

    bank_window_match #(.CPU_AW(CPU_AW), .PASS_W(PASS_W)) u_match (
        .cpu_a(cpu_a), .base_q(base_q), .mask_q(mask_q), .in_win(banked)
    );

    bank_addr_compose #(.CPU_AW(CPU_AW), .PHY_AW(PHY_AW), .PASS_W(PASS_W)) u_compose (
        .cpu_a(cpu_a), .mask_q(mask_q), .page_q(page_q), .in_win(banked),
        .phys_a(phys_a)
    );
endmodule

// File: rtl/bank_remapper_chk.sv
// Checker: temporal properties of the bank remapper, bound to the top.
module bank_remapper_chk
    import bank_remap_pkg::*;
#(
    parameter logic [7:0] SWAP_PORT = 8'h38,
    parameter logic [7:0] SWAP_VAL  = 8'h20
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [CPU_AW-1:0]        cpu_a,
    input logic                     io_wr,
    input logic [7:0]               io_port,
    input logic                     reg_we,
    input logic [1:0]               reg_sel,
    input logic [REG_W-1:0]         reg_wdata,
    input logic [PHY_AW-1:0]        phys_a,
    input logic                     banked,
    input logic [CPU_AW-PASS_W-1:0] mask_q,
    input logic [PHY_AW-PASS_W-1:0] page_q
);
    localparam int LO = REG_W - (CPU_AW - PASS_W);

    assert_swap_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_port == SWAP_PORT) |=> (page_q == SWAP_VAL));

    assert_other_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_port != SWAP_PORT && !(reg_we && reg_sel == SEL_PAGE))
        |=> $stable(page_q));

    assert_passthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !banked |-> (phys_a == PHY_AW'(cpu_a)));

    assert_offset_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        banked |-> (phys_a[PASS_W-1:0] == cpu_a[PASS_W-1:0]));

    assert_mask_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == SEL_MASK) |=> (mask_q == $past(reg_wdata[REG_W-1:LO])));
endmodule

bind bank_remapper bank_remapper_chk #(.SWAP_PORT(SWAP_PORT), .SWAP_VAL(SWAP_VAL)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_a(cpu_a), .io_wr(io_wr), .io_port(io_port),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .phys_a(phys_a), .banked(banked), .mask_q(mask_q), .page_q(page_q)
);

// File: tb/bank_remapper_tb.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random register and I/O traffic,
// checked against a bench-side model of the three registers.
module bank_remapper_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_a = '0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_port = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic [18:0] phys_a;
    logic        banked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] m_base, m_mask, m_page;

    bank_remapper u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_a(cpu_a), .io_wr(io_wr), .io_port(io_port),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .phys_a(phys_a), .banked(banked)
    );

    always #2.5 clk = ~clk;

    // Expected window hit from R2: bit k of base/mask pairs with CPU bit k+8.
    function automatic bit exp_banked(input logic [15:0] a);
        bit ok = 1'b1;
        for (int i = 11; i < 16; i++)
            if (!m_mask[i-8] && a[i] != m_base[i-8]) ok = 1'b0;
        return ok;
    endfunction

    // Expected SRAM address from R3 and R4.
    function automatic logic [18:0] exp_phys(input logic [15:0] a);
        logic [18:0] p;
        if (!exp_banked(a)) return {3'b000, a};
        p[10:0] = a[10:0];
        for (int i = 11; i < 16; i++) p[i] = m_mask[i-8] ? a[i] : m_page[i-11];
        p[18:16] = m_page[7:5];
        return p;
    endfunction

    task automatic model_reset();
        m_base = 8'h00; m_mask = 8'h1C; m_page = 8'h00;
    endtask

    // Compare both outputs for address a against the model.
    task automatic check_addr(input logic [15:0] a, input string req);
        logic [18:0] ep;
        bit eb;
        cpu_a = a;
        #1;
        ep = exp_phys(a);
        eb = exp_banked(a);
        checks++;
        if (phys_a !== ep || banked !== eb) begin
            errors++;
            $display("FAIL %s addr=%h phys=%h banked=%b expected phys=%h banked=%b",
                     req, a, phys_a, banked, ep, eb);
        end
    endtask

    // One clock of writes; inputs set at negedge, model updated at the edge.
    task automatic do_cycle(input bit we, input logic [1:0] sel, input logic [7:0] wd,
                            input bit iow, input logic [7:0] port);
        @(negedge clk);
        reg_we = we; reg_sel = sel; reg_wdata = wd; io_wr = iow; io_port = port;
        @(posedge clk);
        if (iow && port == 8'h38) m_page = 8'h20;
        else if (we && sel == 2'd2) m_page = wd;
        if (we && sel == 2'd0) m_base = wd;
        if (we && sel == 2'd1) m_mask = wd;
        @(negedge clk);
        reg_we = 1'b0; io_wr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        model_reset();
        @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] a;
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset window 0x0000-0x1FFF on page 0
        check_addr(16'h0000, "R1");
        check_addr(16'h1FFF, "R1");
        check_addr(16'h2000, "R1/R4");
        check_addr(16'hFFFF, "R4");

        // R5: swap write, data bus content irrelevant
        do_cycle(1'b0, 2'd0, 8'h00, 1'b1, 8'h38);
        check_addr(16'h0ABC, "R5");
        if (phys_a !== 19'h10ABC) begin
            errors++;
            $display("FAIL R5 phys=%h expected phys=%h", phys_a, 19'h10ABC);
        end
        checks++;
        check_addr(16'h4000, "R5/R4");

        // R6: other ports ignored
        do_cycle(1'b1, 2'd2, 8'h00, 1'b0, 8'h00);
        do_cycle(1'b0, 2'd0, 8'h00, 1'b1, 8'h39);
        check_addr(16'h0ABC, "R6");
        do_cycle(1'b0, 2'd0, 8'h00, 1'b1, 8'h37);
        check_addr(16'h1800, "R6");

        // R7: select 3 writes nothing
        do_cycle(1'b1, 2'd3, 8'hFF, 1'b0, 8'h00);
        check_addr(16'h1234, "R7");
        check_addr(16'h2345, "R7");

        // R8: swap beats a simultaneous page write
        do_cycle(1'b1, 2'd2, 8'h55, 1'b1, 8'h38);
        check_addr(16'h0123, "R8");

        // R9: reset after swap returns to page 0
        do_reset();
        check_addr(16'h1FFF, "R9");
        check_addr(16'h0040, "R9");

        // R2/R3/R7: random register and I/O traffic
        for (int n = 0; n < 400; n++) begin
            logic [1:0] s = 2'($urandom_range(0, 3));
            bit iow = ($urandom_range(0, 5) == 0);
            logic [7:0] port = ($urandom_range(0, 1) == 0) ? 8'h38 : 8'($urandom);
            do_cycle($urandom_range(0, 1) == 1, s, 8'($urandom), iow, port);
            for (int k = 0; k < 3; k++) begin
                a = 16'($urandom);
                if ($urandom_range(0, 1) == 1) a[15:11] = m_base[7:3];
                check_addr(a, "R2/R3");
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule